// File: doc/BRIEF.md
# Masked Fast GPIO Port

This block controls a 32-bit general-purpose I/O port from a simple register interface. Each bit can be made an input or an output. Output bits can be driven high or low one at a time through separate set and clear registers, or the whole port can be written in one access. The output latch and the live pin levels are read back through separate registers.

A mask register protects a chosen group of bits. Masked bits ignore set, clear and full-port writes, and they read as zero wherever the mask applies. This lets software update a field of the port as a unit without a read-modify-write.

Every register honours per-byte write enables. Pin inputs pass through a two-flop synchronizer before software can read them. The pin-value read works whatever the direction of the pin.

Top module: `gpio_fast_port`

## Requirements
- R1: After reset the direction register, the mask register and the output latch are all zero, so `pin_oe` and `pin_out` are zero.
- R2: The direction register sits at offset 0x00 and reads back as written. `pin_oe` equals it, and a 1 means output.
- R3: A write to offset 0x18 drives high every unmasked, lane-enabled bit written as 1. Every other bit of the latch keeps its value.
- R4: A write to offset 0x1C drives low every unmasked, lane-enabled bit written as 1. Every other bit of the latch keeps its value.
- R5: A write to offset 0x14 copies the write data into every unmasked, lane-enabled bit of the output latch.
- R6: The mask register sits at offset 0x10, and a 1 marks a protected bit. Protected bits of the latch are unchanged by writes to 0x14, 0x18 and 0x1C.
- R7: A read of offset 0x14 returns the pin levels ANDed with the inverted mask. A change on `pin_in` becomes visible after the second rising clock edge, whatever the direction setting.
- R8: A read of offset 0x18 returns the output latch ANDed with the inverted mask. A read of 0x1C returns zero.
- R9: Write-enable bit k allows bits 8k+7..8k to change. Lanes that are not enabled keep their value in every register.
- R10: A write to any other offset changes no register, and a read of it returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 4 | Per-byte write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Output latch to the pads |
| pin_oe | output | 32 | Per-bit output enable (direction) |

## Verification
The hardest situation to reach is one write where the mask and the byte enables disagree within the same lane. Here a bit must stay put because of the mask even though its lane is enabled, and a neighbour must stay put because of its lane.

The stimulus sets a mask over the low half-word first. It then issues full-width and single-lane writes to the set, clear and pin registers, so that each bit's outcome depends on a different one of the two guards. The synchronizer delay is caught by sampling the pin read after one edge and again after two.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned ADDR_W = 5;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_MASK = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_PIN  = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_SET  = 5'h18;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 5'h1C;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } latch_op_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_lane_reg.sv
module gpio_lane_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] lane_bits,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= (q & ~lane_bits) | (wdata & lane_bits);
    end

    // R9: with no write strobe the register holds its value
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  latch_op_e    op,
    input  logic [W-1:0] lane_bits,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] open_bits;
    logic [W-1:0] nxt;

    assign open_bits = lane_bits & ~mask;

    always_comb begin
        nxt = q;
        unique case (op)
            OP_NONE:  nxt = q;
            OP_LOAD:  nxt = (q & ~open_bits) | (wdata & open_bits);
            OP_SET:   nxt = q | (wdata & open_bits);
            OP_CLEAR: nxt = q & ~(wdata & open_bits);
            default:  nxt = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    p_masked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((q ^ $past(q)) & $past(mask)) == '0));
    p_set_only_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SET) |=> (($past(q) & ~q) == '0));
    p_clear_only_lowers_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR) |=> ((~$past(q) & q) == '0));
endmodule

// File: rtl/gpio_fast_port.sv
module gpio_fast_port
    import gpio_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [W/8-1:0]    bus_be,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe
);
    localparam int unsigned LANES = W / 8;

    logic [W-1:0] lane_bits;
    logic [W-1:0] dir_q, mask_q, latch_q, pin_sync;
    latch_op_e    op;
    logic         hit_dir, hit_mask, hit_pin, hit_set, hit_clr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bits[g*8 +: 8] = {8{bus_be[g]}};
    end

    assign hit_dir  = (bus_addr == OFS_DIR);
    assign hit_mask = (bus_addr == OFS_MASK);
    assign hit_pin  = (bus_addr == OFS_PIN);
    assign hit_set  = (bus_addr == OFS_SET);
    assign hit_clr  = (bus_addr == OFS_CLR);

    always_comb begin
        op = OP_NONE;
        if (bus_wen) begin
            if (hit_pin)      op = OP_LOAD;
            else if (hit_set) op = OP_SET;
            else if (hit_clr) op = OP_CLEAR;
        end
    end

    gpio_lane_reg #(.W(W)) u_dir (
        .clk(clk), .rst_n(rst_n), .we(bus_wen && hit_dir),
        .lane_bits(lane_bits), .wdata(bus_wdata), .q(dir_q)
    );

    gpio_lane_reg #(.W(W)) u_mask (
        .clk(clk), .rst_n(rst_n), .we(bus_wen && hit_mask),
        .lane_bits(lane_bits), .wdata(bus_wdata), .q(mask_q)
    );

    gpio_out_latch #(.W(W)) u_latch (
        .clk(clk), .rst_n(rst_n), .op(op), .lane_bits(lane_bits),
        .mask(mask_q), .wdata(bus_wdata), .q(latch_q)
    );

    gpio_pin_sync #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_dir)       bus_rdata = dir_q;
        else if (hit_mask) bus_rdata = mask_q;
        else if (hit_pin)  bus_rdata = pin_sync & ~mask_q;
        else if (hit_set)  bus_rdata = latch_q & ~mask_q;
    end

    assign pin_out = latch_q;
    assign pin_oe  = dir_q;

    p_unmapped_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && !(hit_dir || hit_mask || hit_pin || hit_set || hit_clr))
        |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/gpio_fast_port_test.sv
module gpio_fast_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    gpio_fast_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(5'h00, v); check("R1 dir", v, 32'h0);
        rd(5'h10, v); check("R1 mask", v, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
    endtask

    task automatic t_direction;
        logic [31:0] v;
        wr(5'h00, 4'b0101, 32'hAABBCCDD);
        rd(5'h00, v); check("R2 R9 dir lanes", v, 32'h00BB00DD);
        check("R2 pin_oe", pin_oe, 32'h00BB00DD);
    endtask

    task automatic t_set_clear;
        wr(5'h18, 4'hF, 32'hF0F00000); check("R3 set", pin_out, 32'hF0F00000);
        wr(5'h1C, 4'hF, 32'h30000000); check("R4 clear", pin_out, 32'hC0F00000);
        wr(5'h18, 4'hF, 32'h0000000F); check("R3 set keeps others", pin_out, 32'hC0F0000F);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(5'h10, 4'hF, 32'h0000FFFF);
        rd(5'h10, v); check("R6 mask readback", v, 32'h0000FFFF);
        wr(5'h14, 4'hF, 32'h12345678); check("R5 R6 masked load", pin_out, 32'h1234000F);
        wr(5'h18, 4'hF, 32'h0000FFF0); check("R6 masked set", pin_out, 32'h1234000F);
        wr(5'h1C, 4'b0001, 32'hFFFFFFFF); check("R6 masked clear", pin_out, 32'h1234000F);
        wr(5'h1C, 4'b1000, 32'hFFFFFFFF); check("R9 clear one lane", pin_out, 32'h0034000F);
        rd(5'h18, v); check("R8 set read", v, 32'h00340000);
        rd(5'h1C, v); check("R8 clr read", v, 32'h0);
    endtask

    task automatic t_pin_read;
        logic [31:0] v;
        @(negedge clk); pin_in = 32'hCAFEBABE;
        @(negedge clk); rd(5'h14, v); check("R7 one edge", v, 32'h0);
        @(negedge clk); rd(5'h14, v); check("R7 two edges", v, 32'hCAFE0000);
        wr(5'h10, 4'hF, 32'h0);
        rd(5'h14, v); check("R7 unmasked", v, 32'hCAFEBABE);
    endtask

    task automatic t_lane_load;
        wr(5'h14, 4'b0010, 32'h0000AB00); check("R5 R9 lane load", pin_out, 32'h0034AB0F);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(5'h04, 4'hF, 32'hFFFFFFFF);
        rd(5'h04, v); check("R10 read", v, 32'h0);
        check("R10 pin_out", pin_out, 32'h0034AB0F);
        check("R10 pin_oe", pin_oe, 32'h00BB00DD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_direction;
        t_set_clear;
        t_mask;
        t_pin_read;
        t_lane_load;
        t_unmapped;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule